// File: doc/BRIEF.md
# Button-Selected Pulse Width Generator

This block watches a bank of four clean, synchronous push-button inputs and turns a button action into one output pulse. While a button is held, a light output is on. When every button has been let go, the light goes off and the pulse output goes high for a number of clock cycles set by the button that was used. The first button gives one cycle, the second two, the third three and the fourth four.

The width is chosen while the button is held. If several buttons are down during one hold, the highest-numbered one that was seen wins. Once the pulse has started, the buttons are ignored until the pulse is over and every button has been released. This guard stops a button that is still held from starting a second pulse. Both outputs are decoded from the state register, so the inputs have no combinational path to them.

Top module: `btn_pulse_gen`

## Requirements
- R1: A synchronous active-low reset (`rst_n` low at a rising clock edge) sends the block to idle, and both `light_o` and `pulse_o` are 0 in the cycle that follows.
- R2: In idle, a rising edge that sees any `btn_i` bit at 1 raises `light_o` for the following cycle. `light_o` stays at 1 for as long as each rising edge sees at least one button bit at 1.
- R3: During a hold, the first rising edge that sees `btn_i == 4'b0000` drops `light_o` and raises `pulse_o` for the following cycle.
- R4: The pulse lasts exactly 1, 2, 3 or 4 consecutive cycles when the selecting button is `btn_i[0]`, `btn_i[1]`, `btn_i[2]` or `btn_i[3]`, in that order.
- R5: The selecting button is the highest-numbered bit seen at 1 on any rising edge of the hold. This covers buttons pressed together and buttons added part-way through a hold.
- R6: Button activity while `pulse_o` is high neither lengthens nor shortens the pulse.
- R7: If any button is still held when the pulse ends, both outputs stay at 0 until an edge sees all buttons released. Only a press sampled after that can raise `light_o` again.
- R8: `light_o` and `pulse_o` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| btn_i | input | 4 | Button levels, bit k is button k+1, 1 = pressed |
| light_o | output | 1 | High while a button hold is in progress |
| pulse_o | output | 1 | Width-selected pulse issued after release |

## Verification
The hardest path to reach is the lock-out. It needs a button pressed during a pulse and still held when the pulse ends, so the press must land inside a window that is only one to four cycles long. The stimulus first presses and releases a short button, then presses a different button in the first pulse cycle and keeps it down well past the pulse. A second case presses and releases inside the pulse, which checks that a press in the pulse window has no effect at all. A behavioural model compares both outputs on every cycle, so any pulse that is too long, too short or extra is caught on the cycle where it happens.

// File: rtl/btn_pulse_pkg.sv
// Package btn_pulse_pkg
// Purpose : shared state encoding for the button pulse generator.
// Assumes : nothing beyond a two-bit state register.
package btn_pulse_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HOLD  = 2'd1,
        ST_PULSE = 2'd2,
        ST_LOCK  = 2'd3
    } bp_state_e;

endpackage

// File: rtl/btn_prio_enc.sv
// Module  : btn_prio_enc
// Purpose : reports whether any button is down and the index of the
//           highest-numbered button that is down.
// Assumes : button levels are clean and synchronous to the consumer.
module btn_prio_enc #(
    parameter int N_BTN = 4,
    parameter int IDX_W = 2
) (
    input  logic [N_BTN-1:0] btn_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);

    // Scan from the lowest bit upward so the highest set bit wins.
    always_comb begin
        idx_o = '0;
        for (int k = 0; k < N_BTN; k++) begin
            if (btn_i[k]) idx_o = IDX_W'(k);
        end
    end

    // Any-pressed flag.
    always_comb any_o = |btn_i;

endmodule

// File: rtl/pw_counter.sv
// Module  : pw_counter
// Purpose : down-counter for the remaining pulse cycles; flags the last one.
// Assumes : load and enable are never needed in the same cycle with
//           conflicting intent; load takes priority.
module pw_counter #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             en_i,
    output logic             last_o
);

    logic [CNT_W-1:0] cnt_q;

    // Load the width, then count down while enabled, stopping at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                    cnt_q <= '0;
        else if (load_i)               cnt_q <= load_val_i;
        else if (en_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    // Last pulse cycle when the count has reached zero.
    always_comb last_o = (cnt_q == '0);

endmodule

// File: rtl/pw_ctrl.sv
// Module  : pw_ctrl
// Purpose : hold / pulse / lock-out state machine. It tracks the widest
//           button seen during a hold and drives Moore outputs.
// Assumes : the any/idx inputs come straight from the button encoder;
//           cnt_last_i comes from a counter loaded through cnt_load_o.
module pw_ctrl
    import btn_pulse_pkg::*;
#(
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             any_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic             cnt_last_i,
    output logic             cnt_load_o,
    output logic             cnt_en_o,
    output logic [IDX_W-1:0] width_o,
    output logic             light_o,
    output logic             pulse_o
);

    bp_state_e        state_q, state_d;
    logic [IDX_W-1:0] width_q;

    // Next-state decision.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (any_i)      state_d = ST_HOLD;
            ST_HOLD:  if (!any_i)     state_d = ST_PULSE;
            ST_PULSE: if (cnt_last_i) state_d = any_i ? ST_LOCK : ST_IDLE;
            ST_LOCK:  if (!any_i)     state_d = ST_IDLE;
            default:                  state_d = ST_IDLE;
        endcase
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Width register: take the first press, then keep the widest one seen.
    always_ff @(posedge clk) begin
        if (!rst_n)
            width_q <= '0;
        else if (state_q == ST_IDLE && any_i)
            width_q <= idx_i;
        else if (state_q == ST_HOLD && any_i && idx_i > width_q)
            width_q <= idx_i;
    end

    // Counter control and Moore output decode.
    always_comb begin
        cnt_load_o = (state_q == ST_HOLD) && !any_i;
        cnt_en_o   = (state_q == ST_PULSE);
        width_o    = width_q;
        light_o    = (state_q == ST_HOLD);
        pulse_o    = (state_q == ST_PULSE);
    end

    assert_light_pulse_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(light_o && pulse_o));

    assert_light_needs_press_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(light_o) |-> $past(any_i));

    assert_pulse_after_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_o) |-> $past(light_o && !any_i));

    assert_lock_waits_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOCK && any_i) |=> !light_o && !pulse_o);

endmodule

// File: rtl/btn_pulse_gen.sv
// Module  : btn_pulse_gen
// Purpose : top level. Button bank in; light while held; pulse of
//           1..N_BTN cycles after release.
// Assumes : buttons are debounced and synchronous to clk.
module btn_pulse_gen #(
    parameter int N_BTN = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_BTN-1:0] btn_i,
    output logic             light_o,
    output logic             pulse_o
);

    localparam int IDX_W = (N_BTN > 1) ? $clog2(N_BTN) : 1;
    localparam int RUN_W = $clog2(N_BTN + 1) + 1;

    logic             any_w;
    logic [IDX_W-1:0] idx_w;
    logic [IDX_W-1:0] width_w;
    logic             cnt_load_w;
    logic             cnt_en_w;
    logic             cnt_last_w;

    btn_prio_enc #(.N_BTN(N_BTN), .IDX_W(IDX_W)) u_enc (
        .btn_i (btn_i),
        .any_o (any_w),
        .idx_o (idx_w)
    );

    pw_ctrl #(.IDX_W(IDX_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .any_i      (any_w),
        .idx_i      (idx_w),
        .cnt_last_i (cnt_last_w),
        .cnt_load_o (cnt_load_w),
        .cnt_en_o   (cnt_en_w),
        .width_o    (width_w),
        .light_o    (light_o),
        .pulse_o    (pulse_o)
    );

    pw_counter #(.CNT_W(IDX_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (cnt_load_w),
        .load_val_i (width_w),
        .en_i       (cnt_en_w),
        .last_o     (cnt_last_w)
    );

    // Pulse run length tracker used only by the length assertions below.
    logic [RUN_W-1:0] run_q;
    always_ff @(posedge clk) begin
        if (!rst_n)       run_q <= '0;
        else if (pulse_o) run_q <= run_q + 1'b1;
        else              run_q <= '0;
    end

    assert_pulse_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pulse_o) |-> (32'(run_q) == 32'(width_w) + 1));

    assert_pulse_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
        32'(run_q) <= N_BTN);

endmodule

// File: tb/tb_btn_pulse_gen.sv
module tb_btn_pulse_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] btn = 4'b0000;
    logic       light, pulse;

    int    checks = 0;
    int    fails  = 0;
    int    cycles = 0;
    string phase  = "R1 reset";

    // Behavioural reference: mode 0 idle, 1 holding, 2 pulsing, 3 waiting.
    int m_mode   = 0;
    int m_best   = 0;
    int m_remain = 0;

    btn_pulse_gen dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .btn_i   (btn),
        .light_o (light),
        .pulse_o (pulse)
    );

    always #2.5 clk = ~clk;

    function automatic int top_btn(input logic [3:0] b);
        int r = 0;
        for (int k = 0; k < 4; k++) if (b[k]) r = k + 1;
        return r;
    endfunction

    // Reference update on each rising edge.
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_mode = 0; m_best = 0; m_remain = 0;
        end else begin
            case (m_mode)
                0: if (btn != 0) begin m_mode = 1; m_best = top_btn(btn); end
                1: if (btn != 0) begin
                       if (top_btn(btn) > m_best) m_best = top_btn(btn);
                   end else begin
                       m_mode = 2; m_remain = m_best;
                   end
                2: begin
                       m_remain--;
                       if (m_remain == 0) m_mode = (btn != 0) ? 3 : 0;
                   end
                default: if (btn == 0) m_mode = 0;
            endcase
        end
    end

    // Compare both outputs with the model, away from the edge.
    task automatic compare();
        logic el = (m_mode == 1);
        logic ep = (m_mode == 2);
        checks++;
        if (light !== el || pulse !== ep) begin
            fails++;
            $display("FAIL %s: light=%b pulse=%b expected light=%b pulse=%b at cycle %0d",
                     phase, light, pulse, el, ep, cycles);
        end
    endtask

    task automatic step(input logic [3:0] b, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare();
            btn = b;
        end
    endtask

    task automatic press_release(input logic [3:0] b, input int hold, input int idle);
        step(b, hold);
        step(4'b0000, idle);
    endtask

    initial begin
        // R1: reset state.
        phase = "R1 reset";
        btn = 4'b0110;
        step(4'b0110, 3);
        @(negedge clk); rst_n = 1'b1; btn = 4'b0000;
        step(4'b0000, 3);

        // R2, R3, R4: each single button gives its own width.
        for (int k = 0; k < 4; k++) begin
            phase = $sformatf("R4 width of button %0d (R2 R3)", k + 1);
            press_release(4'b0001 << k, 3, 8);
        end

        // R5: buttons pressed together, highest wins.
        phase = "R5 simultaneous 0101";
        press_release(4'b0101, 2, 8);
        // R5: widest button added part-way through a hold.
        phase = "R5 added mid-hold";
        step(4'b0001, 2);
        step(4'b1001, 2);
        step(4'b0001, 2);
        step(4'b0000, 8);

        // R6: press and release inside a two-cycle pulse.
        phase = "R6 press during pulse";
        step(4'b0010, 2);
        step(4'b0000, 1);
        step(4'b1000, 1);
        step(4'b0000, 8);

        // R7: a button still held at pulse end locks out.
        phase = "R7 lock-out";
        step(4'b0001, 2);
        step(4'b0000, 1);
        step(4'b0100, 6);
        step(4'b0000, 2);
        phase = "R7 re-press after lock";
        press_release(4'b0100, 2, 8);

        // R8 is checked on every cycle above; R1 reset in mid-hold.
        phase = "R1 reset mid-hold R8";
        step(4'b1000, 2);
        @(negedge clk); compare(); rst_n = 1'b0;
        step(4'b1000, 2);
        @(negedge clk); compare(); rst_n = 1'b1; btn = 4'b0000;
        step(4'b0000, 3);
        press_release(4'b0010, 1, 6);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run is counted as a failure.
    initial begin
        #50000;
        checks++;
        fails++;
        $display("FAIL watchdog: run did not finish, actual cycles=%0d expected<10000", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule